// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block keeps one pending flag for each of seven interrupt sources of a processor core. From those flags it picks the single interrupt the core should take next. Each source is set by a one-cycle pulse and removed by its own one-cycle clear pulse. The logic that produces those clears is outside the block: a register write for the hypervisor tick match, a bus access for the interrupt vector, and the trap-level-zero enable going low. A 16-bit soft-interrupt vector arrives directly from outside.

The choice depends on two mode inputs: a hypervisor-privilege bit and an interrupt-enable bit.

- With privilege set, only the tick match and the vector source can win, and only when enable is also set.
- With privilege clear, three sources are taken whether or not enable is set: trap-level-zero, tick match and vector, in that order.
- With privilege clear and enable set, four lower sources follow, in this order: CPU mondo, device mondo, soft interrupt, resumable error.

When the soft source wins, the block also reports a level number taken from the soft vector.

The pending flags are registered. The selection is combinational from those flags, so a source that is set on one clock edge is visible on the outputs right after that edge.

Top module: `irq_prio_select`

## Requirements
- R1: The type output encodes the winner as 0 trap-level-zero, 1 hypervisor tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 soft interrupt. The bit index of set_i and clr_i matches this code.
- R2: Ready is low whenever no pending flag is set and the soft vector is zero. A source pulsed on set_i at a clock edge drives ready and type right after that edge. While ready is low, type and level read 0.
- R3: With hpriv_i=1 and ie_i=1, the tick match (1) wins over the vector (2). With hpriv_i=1 and ie_i=0, ready is low.
- R4: With hpriv_i=1, sources 0, 3, 4, 5 and 6 are never taken, whatever ie_i is and whatever the soft vector holds.
- R5: With hpriv_i=0, trap-level-zero wins over tick match, and tick match wins over vector. These three are taken whatever ie_i is.
- R6: With hpriv_i=0 and ie_i=1, the sources below the first three are ranked CPU mondo, device mondo, soft interrupt, resumable error. With ie_i=0, none of these four is taken.
- R7: The soft source is pending when its flag (bit 6) is set or when any bit of the soft vector is set.
- R8: When the soft source wins, level is the index of the highest set bit among soft vector bits 1 to 15, and 0 if none of them is set. Bit 0 never sets the level. Level reads 0 when any other source wins.
- R9: A set pulse and a clear pulse for the same source in the same cycle leave the flag set. A clear pulse alone drops that source's flag at the next edge and leaves every other flag unchanged.
- R10: Synchronous active-high reset clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 7 | Per-source set pulses, indexed by type code |
| clr_i | input | 7 | Per-source clear pulses, indexed by type code |
| soft_vec_i | input | 16 | Soft-interrupt pending vector |
| hpriv_i | input | 1 | Hypervisor-privilege mode |
| ie_i | input | 1 | Interrupt enable |
| irq_ready_o | output | 1 | An interrupt is ready to be taken |
| irq_type_o | output | 3 | Code of the winning source |
| soft_level_o | output | 4 | Level of the soft interrupt when it wins |

## Verification
Two of this block's actions can fall in the same clock: a source's set pulse and its own clear pulse. The bench provokes this by driving both bits for one source in a single cycle. It judges the result by whether that source is still the reported winner on the next cycle. A second test drives a clear alone on one of two pending sources and confirms that the other source takes over, which shows the clear touched only its own flag. A vector table then loads each flag pattern under every privilege and enable combination and compares ready, type and level with values derived from the ranking rules.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NUM_SRC = 7;
  localparam int SOFT_W  = 16;
  localparam int TYPE_W  = $clog2(NUM_SRC);

  typedef enum logic [TYPE_W-1:0] {
    SRC_TLZ       = 3'd0,
    SRC_HTICK     = 3'd1,
    SRC_IVEC      = 3'd2,
    SRC_CPU_MONDO = 3'd3,
    SRC_DEV_MONDO = 3'd4,
    SRC_RES_ERR   = 3'd5,
    SRC_SOFT      = 3'd6
  } src_e;

  // Service order for the non-privileged, enabled case; first entry wins.
  localparam src_e RANK [NUM_SRC] = '{SRC_TLZ, SRC_HTICK, SRC_IVEC,
                                      SRC_CPU_MONDO, SRC_DEV_MONDO,
                                      SRC_SOFT, SRC_RES_ERR};
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        pend_o[k] <= 1'b0;
      else if (set_i[k])
        pend_o[k] <= 1'b1;
      else if (clr_i[k])
        pend_o[k] <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> pend_o[k]);
    // R9
    clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[k] && !set_i[k]) |=> $stable(pend_o[k]));
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_o == '0));
endmodule

// File: rtl/soft_level_enc.sv
module soft_level_enc #(
  parameter int W  = 16,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [LW-1:0] lvl_o
);
  // Highest set bit among 1..W-1; bit 0 has no level.
  always_comb begin
    lvl_o = '0;
    for (int b = 1; b < W; b++)
      if (vec_i[b]) lvl_o = LW'(b);
  end

  // R8
  lvl_bit_chk: assert final ((lvl_o == '0) || vec_i[lvl_o]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               global_i,
  input  logic               hpriv_i,
  input  logic               ie_i,
  output logic               ready_o,
  output src_e               type_o
);
  localparam logic [NUM_SRC-1:0] HP_MASK  = NUM_SRC'(7'b0000110);
  localparam logic [NUM_SRC-1:0] TOP_MASK = NUM_SRC'(7'b0000111);

  logic [NUM_SRC-1:0] elig;
  src_e               win;

  always_comb begin
    if (hpriv_i)
      elig = ie_i ? (pend_i & HP_MASK) : '0;
    else
      elig = pend_i & (ie_i ? '1 : TOP_MASK);
  end

  always_comb begin
    win = SRC_TLZ;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (elig[RANK[i]]) win = RANK[i];
  end

  assign ready_o = global_i && (elig != '0);
  assign type_o  = ready_o ? win : SRC_TLZ;

  // R2
  ready_needs_global_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> global_i);
  // R4
  hp_types_chk: assert property (@(posedge clk) disable iff (rst)
    (hpriv_i && ready_o) |-> (type_o == SRC_HTICK || type_o == SRC_IVEC));
  // R3
  hp_ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (hpriv_i && !ie_i) |-> !ready_o);
  // R6
  low_ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!hpriv_i && !ie_i && ready_o) |-> (type_o <= SRC_IVEC));
  // R5
  tlz_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!hpriv_i && pend_i[SRC_TLZ]) |-> (ready_o && type_o == SRC_TLZ));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int SOFT_BITS = SOFT_W,
  parameter int LVL_W     = $clog2(SOFT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   set_i,
  input  logic [NUM_SRC-1:0]   clr_i,
  input  logic [SOFT_BITS-1:0] soft_vec_i,
  input  logic                 hpriv_i,
  input  logic                 ie_i,
  output logic                 irq_ready_o,
  output logic [TYPE_W-1:0]    irq_type_o,
  output logic [LVL_W-1:0]     soft_level_o
);
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] pend_eff;
  logic [LVL_W-1:0]   lvl;
  logic               global_pend;
  src_e               win;

  irq_pend_bank #(.N(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_i), .clr_i(clr_i), .pend_o(flags)
  );

  soft_level_enc #(.W(SOFT_BITS), .LW(LVL_W)) u_lvl (
    .vec_i(soft_vec_i), .lvl_o(lvl)
  );

  always_comb begin
    pend_eff           = flags;
    pend_eff[SRC_SOFT] = flags[SRC_SOFT] | (|soft_vec_i);
  end

  assign global_pend = (|flags) | (|soft_vec_i);

  irq_arbiter u_arb (
    .clk(clk), .rst(rst), .pend_i(pend_eff), .global_i(global_pend),
    .hpriv_i(hpriv_i), .ie_i(ie_i), .ready_o(irq_ready_o), .type_o(win)
  );

  assign irq_type_o   = win;
  assign soft_level_o = (irq_ready_o && win == SRC_SOFT) ? lvl : '0;

  // R8
  lvl_only_soft_chk: assert property (@(posedge clk) disable iff (rst)
    (win != SRC_SOFT) |-> (soft_level_o == '0));
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (flags == '0 && soft_vec_i == '0) |-> !irq_ready_o);
endmodule

// File: tb/sim_irq_prio_select.sv
`timescale 1ns/1ps
module sim_irq_prio_select;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] set_i = '0, clr_i = '0;
  logic [15:0] soft_vec_i = '0;
  logic       hpriv_i = 1'b0, ie_i = 1'b0;
  logic       irq_ready_o;
  logic [2:0] irq_type_o;
  logic [3:0] soft_level_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_select u0 (.*);

  // {hpriv, ie, flags[6:0], soft[15:0], ready, type, level}
  localparam int NV = 17;
  localparam logic [32:0] TBL [NV] = '{
    {1'b0,1'b0,7'b0000000,16'h0000,1'b0,3'd0,4'd0},
    {1'b0,1'b0,7'b1111111,16'h0000,1'b1,3'd0,4'd0},
    {1'b0,1'b0,7'b1111110,16'h0000,1'b1,3'd1,4'd0},
    {1'b0,1'b0,7'b1111100,16'h0000,1'b1,3'd2,4'd0},
    {1'b0,1'b0,7'b1111000,16'h0000,1'b0,3'd0,4'd0},
    {1'b0,1'b1,7'b1111000,16'h0000,1'b1,3'd3,4'd0},
    {1'b0,1'b1,7'b1110000,16'h0000,1'b1,3'd4,4'd0},
    {1'b0,1'b1,7'b1100000,16'h0020,1'b1,3'd6,4'd5},
    {1'b0,1'b1,7'b0100000,16'h0000,1'b1,3'd5,4'd0},
    {1'b0,1'b1,7'b0000000,16'h8001,1'b1,3'd6,4'd15},
    {1'b0,1'b1,7'b0000000,16'h0001,1'b1,3'd6,4'd0},
    {1'b1,1'b1,7'b1111111,16'h0000,1'b1,3'd1,4'd0},
    {1'b1,1'b1,7'b1111101,16'h0000,1'b1,3'd2,4'd0},
    {1'b1,1'b0,7'b1111111,16'h0000,1'b0,3'd0,4'd0},
    {1'b1,1'b1,7'b1111001,16'hffff,1'b0,3'd0,4'd0},
    {1'b0,1'b1,7'b1000000,16'h0300,1'b1,3'd6,4'd9},
    {1'b0,1'b1,7'b0001000,16'h0006,1'b1,3'd3,4'd0}
  };
  localparam string TAG [NV] = '{"R2","R5","R5","R5","R6","R6","R6","R7",
    "R6","R8","R8","R3","R3","R3","R4","R8","R8"};

  task automatic chk(string req, logic r, logic [2:0] t, logic [3:0] l);
    checks++;
    if (irq_ready_o !== r || irq_type_o !== t || soft_level_o !== l) begin
      errors++;
      $display("FAIL %s: got rdy=%b type=%0d lvl=%0d exp rdy=%b type=%0d lvl=%0d",
               req, irq_ready_o, irq_type_o, soft_level_o, r, t, l);
    end
  endtask

  task automatic pulse(logic [6:0] s, logic [6:0] c);
    set_i = s; clr_i = c;
    @(negedge clk);
    set_i = '0; clr_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10", 1'b0, 3'd0, 4'd0);   // reset state
    for (int i = 0; i < NV; i++) begin
      {hpriv_i, ie_i} = TBL[i][32:31];
      pulse('0, 7'h7f);
      soft_vec_i = TBL[i][23:8];
      pulse(TBL[i][30:24], '0);
      chk(TAG[i], TBL[i][7], TBL[i][6:4], TBL[i][3:0]);
    end
    // R2 R1: output visible right after the set edge
    hpriv_i = 1'b0; ie_i = 1'b1; soft_vec_i = '0;
    pulse('0, 7'h7f);
    chk("R2", 1'b0, 3'd0, 4'd0);
    pulse(7'b0010000, '0);
    chk("R1", 1'b1, 3'd4, 4'd0);
    // R9 set and clear same source same cycle
    pulse('0, 7'h7f);
    pulse(7'b0000100, 7'b0000100);
    chk("R9", 1'b1, 3'd2, 4'd0);
    pulse('0, 7'b0000100);
    chk("R9", 1'b0, 3'd0, 4'd0);
    // R9 clear touches only its own source
    pulse(7'b0001010, '0);
    chk("R9", 1'b1, 3'd1, 4'd0);
    pulse('0, 7'b0000010);
    chk("R9", 1'b1, 3'd3, 4'd0);
    // R7 soft flag alone, level 0
    pulse(7'b1000000, 7'b0001000);
    chk("R7", 1'b1, 3'd6, 4'd0);
    // R10 reset clears flags
    pulse(7'h7f, '0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R10", 1'b0, 3'd0, 4'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule